// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block turns one high-level flash request into the series of bus write cycles that a byte-wide parallel NOR flash expects on its address, data and active-low write-enable pins. It handles seven operations: byte program, sector erase, block erase, whole-chip erase, entry into identification mode, exit from identification mode, and reset. Each operation begins with the two-write unlock handshake, except for a short exit or reset. A fixed command byte then follows, and in some cases a data byte or a target address.

Four configuration inputs shape the sequence. One selects how many low address bits the command addresses keep. One swaps the two unlock addresses. One adds the unlock pair in front of the exit/reset write. One removes the settle gap between writes. These inputs are captured when a request is accepted. The block pulses `done` once the final write has been issued. Polling the flash for completion and checking the data written are handled elsewhere.

Top module: `nor_cmd_seq`

## Requirements
- R1: Every sequence except a short exit/reset starts with two unlock writes. The first writes 0xAA to the first unlock address (0x5555 before masking). The second writes 0x55 to the second unlock address (0x2AAA before masking).
- R2: When `cfg_shifted` is 1, the first unlock address becomes 0x2AAA and the second becomes 0x5555. This holds in every write that uses an unlock address.
- R3: Unlock addresses are ANDed with a mask chosen by `cfg_mask_sel`: 0 → 0xFFFF, 1 → 0x07FF, 2 → 0x0FFF, 3 → 0xFFFF. Bits at position 16 and above are zero. Target addresses from `req_addr` are driven unmasked.
- R4: Program (`req_op`=0) is four writes. After the unlock pair comes 0xA0 to the first unlock address, then `req_data` to `req_addr`.
- R5: Sector erase (op 1), block erase (op 2) and chip erase (op 3) are six writes each: unlock pair, 0x80 to the first unlock address, unlock pair again, then a final write. The final write is 0x30 to `req_addr`, 0x50 to `req_addr`, or 0x10 to the first unlock address, respectively.
- R6: ID entry (op 4) is the unlock pair followed by 0x90 to the first unlock address. ID exit (op 5) and reset (op 6) are a single 0xF0 write to the first unlock address. When `cfg_long_reset` is 1, the unlock pair comes before that write.
- R7: Each write has three parts. For one clock the address and data are driven with `fl_we_n` high. Then `fl_we_n` is low for `WE_LOW_CLKS` clocks. Then address and data are held for one further clock with `fl_we_n` high. When idle, `fl_we_n` is 1 and address and data are 0.
- R8: Between two writes of one sequence there are `GAP_CLKS` clocks in which the previous address and data stay driven. This gap is left out when `cfg_zero_gap` is 1, and there is never a gap after the final write.
- R9: `busy` rises in the clock after acceptance and stays high through the hold clock of the final write. `done` is high for exactly the next clock, when `busy` is already low.
- R10: The block ignores a request while `busy` is high, and it also ignores a request with `req_op`=7. Configuration changes made while busy do not affect the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R4–R6, R10) |
| req_addr | input | ADDR_W | Target address for program and sector/block erase |
| req_data | input | 8 | Byte to program |
| cfg_mask_sel | input | 2 | Unlock address mask select |
| cfg_shifted | input | 1 | Swap the unlock addresses |
| cfg_long_reset | input | 1 | Put the unlock pair before exit/reset |
| cfg_zero_gap | input | 1 | Suppress the gap between writes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse after the final write |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_data | output | 8 | Flash data bus |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
The bench builds the block with ADDR_W=20, WE_LOW_CLKS=3 and GAP_CLKS=4. The 20-bit address shows that target addresses keep their upper bits while unlock addresses are masked to 16 bits or fewer. The short low period and gap keep every sequence under about sixty clocks, so every operation, mask setting, shifted and long-reset variant, and the zero-gap path can all be compared clock by clock. A low count of 3 (not 1) lets the model catch an off-by-one in the write-enable timer.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_PROG  = 3'd0,
        OP_SECT  = 3'd1,
        OP_BLK   = 3'd2,
        OP_CHIP  = 3'd3,
        OP_IDIN  = 3'd4,
        OP_IDOUT = 3'd5,
        OP_RST   = 3'd6,
        OP_RSVD  = 3'd7
    } nor_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HOLD,
        PH_GAP
    } nor_phase_e;

    localparam logic [15:0] UNLOCK_FIRST  = 16'h5555;
    localparam logic [15:0] UNLOCK_SECOND = 16'h2AAA;

    localparam logic [7:0] BYTE_UNL1   = 8'hAA;
    localparam logic [7:0] BYTE_UNL2   = 8'h55;
    localparam logic [7:0] BYTE_PROG   = 8'hA0;
    localparam logic [7:0] BYTE_ERSETUP= 8'h80;
    localparam logic [7:0] BYTE_SECT   = 8'h30;
    localparam logic [7:0] BYTE_BLK    = 8'h50;
    localparam logic [7:0] BYTE_CHIP   = 8'h10;
    localparam logic [7:0] BYTE_IDIN   = 8'h90;
    localparam logic [7:0] BYTE_EXIT   = 8'hF0;

    function automatic logic [15:0] mask_for(input logic [1:0] sel);
        case (sel)
            2'd1:    return 16'h07FF;
            2'd2:    return 16'h0FFF;
            default: return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/nor_addr_map.sv
module nor_addr_map
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [1:0]        mask_sel,
    input  logic              shifted,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] second_addr
);
    generate
        if (ADDR_W < 16) begin : g_bad_width
            $error("nor_addr_map: ADDR_W must be at least 16");
        end
    endgenerate

    logic [15:0] mask;
    logic [15:0] a_first;
    logic [15:0] a_second;

    always_comb begin
        mask        = mask_for(mask_sel);
        a_first     = shifted ? UNLOCK_SECOND : UNLOCK_FIRST;
        a_second    = shifted ? UNLOCK_FIRST  : UNLOCK_SECOND;
        first_addr  = '0;
        second_addr = '0;
        first_addr[15:0]  = a_first  & mask;
        second_addr[15:0] = a_second & mask;
    end
endmodule

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  nor_op_e           op,
    input  logic [IDX_W-1:0]  idx,
    input  logic              long_reset,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] second_addr,
    input  logic [ADDR_W-1:0] target,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [7:0]        cyc_data,
    output logic              cyc_last
);
    // Unlock slots: even position of a pair goes to the first address
    always_comb begin
        cyc_addr = '0;
        cyc_data = '0;
        cyc_last = 1'b0;
        case (op)
            OP_PROG: begin
                case (idx)
                    3'd0:    begin cyc_addr = first_addr;  cyc_data = BYTE_UNL1; end
                    3'd1:    begin cyc_addr = second_addr; cyc_data = BYTE_UNL2; end
                    3'd2:    begin cyc_addr = first_addr;  cyc_data = BYTE_PROG; end
                    default: begin cyc_addr = target;      cyc_data = wdata; cyc_last = 1'b1; end
                endcase
            end
            OP_SECT, OP_BLK, OP_CHIP: begin
                case (idx)
                    3'd0, 3'd3: begin cyc_addr = first_addr;  cyc_data = BYTE_UNL1; end
                    3'd1, 3'd4: begin cyc_addr = second_addr; cyc_data = BYTE_UNL2; end
                    3'd2:       begin cyc_addr = first_addr;  cyc_data = BYTE_ERSETUP; end
                    default: begin
                        cyc_last = 1'b1;
                        if (op == OP_SECT) begin
                            cyc_addr = target;     cyc_data = BYTE_SECT;
                        end else if (op == OP_BLK) begin
                            cyc_addr = target;     cyc_data = BYTE_BLK;
                        end else begin
                            cyc_addr = first_addr; cyc_data = BYTE_CHIP;
                        end
                    end
                endcase
            end
            OP_IDIN: begin
                case (idx)
                    3'd0:    begin cyc_addr = first_addr;  cyc_data = BYTE_UNL1; end
                    3'd1:    begin cyc_addr = second_addr; cyc_data = BYTE_UNL2; end
                    default: begin cyc_addr = first_addr;  cyc_data = BYTE_IDIN; cyc_last = 1'b1; end
                endcase
            end
            OP_IDOUT, OP_RST: begin
                if (long_reset && idx == 3'd0) begin
                    cyc_addr = first_addr;  cyc_data = BYTE_UNL1;
                end else if (long_reset && idx == 3'd1) begin
                    cyc_addr = second_addr; cyc_data = BYTE_UNL2;
                end else begin
                    cyc_addr = first_addr;  cyc_data = BYTE_EXIT; cyc_last = 1'b1;
                end
            end
            default: cyc_last = 1'b1;
        endcase
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int WE_LOW_CLKS = 4,
    // settle gap between writes; 1000 clocks is 10 us at 100 MHz
    parameter int GAP_CLKS    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic [1:0]        cfg_mask_sel,
    input  logic              cfg_shifted,
    input  logic              cfg_long_reset,
    input  logic              cfg_zero_gap,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_data,
    output logic              fl_we_n
);
    localparam int IDX_W   = 3;
    localparam int LOW_N   = (WE_LOW_CLKS < 1) ? 1 : WE_LOW_CLKS;
    localparam int TMR_MAX = (LOW_N > GAP_CLKS) ? LOW_N : GAP_CLKS;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic NO_GAP = (GAP_CLKS < 1);

    typedef struct packed {
        nor_phase_e        phase;
        nor_op_e           op;
        logic [ADDR_W-1:0] tgt;
        logic [7:0]        wd;
        logic [1:0]        msel;
        logic              shf;
        logic              lng;
        logic              zg;
        logic [IDX_W-1:0]  idx;
        logic [TMR_W-1:0]  tmr;
        logic              done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [ADDR_W-1:0] first_addr, second_addr, cyc_addr;
    logic [7:0]        cyc_data;
    logic              cyc_last;

    nor_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .mask_sel    (st_q.msel),
        .shifted     (st_q.shf),
        .first_addr  (first_addr),
        .second_addr (second_addr)
    );

    nor_cmd_rom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rom (
        .op          (st_q.op),
        .idx         (st_q.idx),
        .long_reset  (st_q.lng),
        .first_addr  (first_addr),
        .second_addr (second_addr),
        .target      (st_q.tgt),
        .wdata       (st_q.wd),
        .cyc_addr    (cyc_addr),
        .cyc_data    (cyc_data),
        .cyc_last    (cyc_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && nor_op_e'(req_op) != OP_RSVD) begin
                    st_d.phase = PH_SETUP;
                    st_d.op    = nor_op_e'(req_op);
                    st_d.tgt   = req_addr;
                    st_d.wd    = req_data;
                    st_d.msel  = cfg_mask_sel;
                    st_d.shf   = cfg_shifted;
                    st_d.lng   = cfg_long_reset;
                    st_d.zg    = cfg_zero_gap;
                    st_d.idx   = '0;
                end
            end
            PH_SETUP: begin
                st_d.phase = PH_LOW;
                st_d.tmr   = TMR_W'(LOW_N - 1);
            end
            PH_LOW: begin
                if (st_q.tmr == '0) st_d.phase = PH_HOLD;
                else                st_d.tmr   = st_q.tmr - 1'b1;
            end
            PH_HOLD: begin
                if (cyc_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end else if (st_q.zg || NO_GAP) begin
                    st_d.phase = PH_SETUP;
                    st_d.idx   = st_q.idx + 1'b1;
                end else begin
                    st_d.phase = PH_GAP;
                    st_d.tmr   = TMR_W'(GAP_CLKS - 1);
                end
            end
            PH_GAP: begin
                if (st_q.tmr == '0) begin
                    st_d.phase = PH_SETUP;
                    st_d.idx   = st_q.idx + 1'b1;
                end else begin
                    st_d.tmr = st_q.tmr - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.op    <= OP_PROG;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.phase != PH_IDLE);
    assign done    = st_q.done;
    assign fl_we_n = (st_q.phase != PH_LOW);
    assign fl_addr = busy ? cyc_addr : '0;
    assign fl_data = busy ? cyc_data : '0;

    // R7
    we_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> busy);

    // R7
    setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_data)));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_data)));

    // R9
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 20;
    localparam int WL   = 3;
    localparam int GAP  = 4;
    localparam int WDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [1:0]    cfg_mask_sel = '0;
    logic          cfg_shifted = 1'b0;
    logic          cfg_long_reset = 1'b0;
    logic          cfg_zero_gap = 1'b0;
    logic          busy, done, fl_we_n;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .WE_LOW_CLKS(WL), .GAP_CLKS(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .cfg_mask_sel(cfg_mask_sel),
        .cfg_shifted(cfg_shifted), .cfg_long_reset(cfg_long_reset),
        .cfg_zero_gap(cfg_zero_gap), .busy(busy), .done(done),
        .fl_addr(fl_addr), .fl_data(fl_data), .fl_we_n(fl_we_n)
    );

    typedef struct {
        logic          we_n;
        logic          busy;
        logic          done;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } sample_t;

    sample_t   expq[$];
    int        n_cmp = 0;
    int        n_bad = 0;
    int        cycles = 0;
    string     cur_tag = "R7";
    logic [AW-1:0] wa[$];
    logic [7:0]    wdq[$];

    function automatic void put(input logic [7:0] d, input logic [AW-1:0] a);
        wdq.push_back(d);
        wa.push_back(a);
    endfunction

    // Reference: list of writes, then per-clock expansion
    function automatic void model_cmd(input int op, input logic [AW-1:0] tgt,
                                      input logic [7:0] wd, input int msel,
                                      input bit shf, input bit lng, input bit zg);
        int m;
        logic [AW-1:0] f, s;
        sample_t e;
        m = (msel == 1) ? 'h7FF : (msel == 2) ? 'hFFF : 'hFFFF;
        f = AW'((shf ? 'h2AAA : 'h5555) & m);
        s = AW'((shf ? 'h5555 : 'h2AAA) & m);
        wa.delete(); wdq.delete();
        if (op <= 4 || lng) begin put(8'hAA, f); put(8'h55, s); end
        case (op)
            0: begin put(8'hA0, f); put(wd, tgt); end
            1, 2, 3: begin
                put(8'h80, f); put(8'hAA, f); put(8'h55, s);
                if (op == 1) put(8'h30, tgt);
                else if (op == 2) put(8'h50, tgt);
                else put(8'h10, f);
            end
            4: put(8'h90, f);
            default: put(8'hF0, f);
        endcase
        for (int i = 0; i < wa.size(); i++) begin
            e.busy = 1'b1; e.done = 1'b0; e.addr = wa[i]; e.data = wdq[i];
            e.we_n = 1'b1; expq.push_back(e);
            e.we_n = 1'b0; for (int k = 0; k < WL; k++) expq.push_back(e);
            e.we_n = 1'b1; expq.push_back(e);
            if (i != wa.size() - 1 && !zg)
                for (int k = 0; k < GAP; k++) expq.push_back(e);
        end
        e.busy = 1'b0; e.done = 1'b1; e.we_n = 1'b1; e.addr = '0; e.data = '0;
        expq.push_back(e);
    endfunction

    function automatic void chk(input string tag, input string what,
                                input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            sample_t e;
            if (expq.size() != 0) e = expq.pop_front();
            else begin
                e.we_n = 1'b1; e.busy = 1'b0; e.done = 1'b0; e.addr = '0; e.data = '0;
            end
            n_cmp++;
            chk("R7", "we_n", 32'(fl_we_n), 32'(e.we_n));
            chk("R9", "busy", 32'(busy), 32'(e.busy));
            chk("R9", "done", 32'(done), 32'(e.done));
            chk(cur_tag, "addr", 32'(fl_addr), 32'(e.addr));
            chk(cur_tag, "data", 32'(fl_data), 32'(e.data));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            n_bad++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(input int op, input logic [AW-1:0] tgt, input logic [7:0] wd);
        @(negedge clk); #1;
        req_valid = 1'b1; req_op = 3'(op); req_addr = tgt; req_data = wd;
        if (expq.size() == 0 && op != 7)
            model_cmd(op, tgt, wd, int'(cfg_mask_sel), cfg_shifted, cfg_long_reset, cfg_zero_gap);
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state checked directly, R7
        n_cmp++;
        chk("R7", "reset we_n", 32'(fl_we_n), 32'd1);
        chk("R9", "reset busy", 32'(busy), 32'd0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        cur_tag = "R4"; // R1 unlock pair + program, full mask
        issue(0, 20'hABCDE, 8'h3C); drain();
        cur_tag = "R2"; cfg_shifted = 1'b1;
        issue(0, 20'h00010, 8'hC3); drain();
        cfg_shifted = 1'b0;
        cur_tag = "R3"; cfg_mask_sel = 2'd1;
        issue(1, 20'h12345, 8'h00); drain();
        cur_tag = "R5"; cfg_mask_sel = 2'd2;
        issue(2, 20'hF8000, 8'h00); drain();
        cfg_mask_sel = 2'd3;
        issue(3, 20'h0, 8'h00); drain();
        cfg_mask_sel = 2'd0;
        cur_tag = "R6";
        issue(4, 20'h0, 8'h00); drain();
        issue(5, 20'h0, 8'h00); drain();
        cfg_long_reset = 1'b1; cfg_shifted = 1'b1;
        issue(6, 20'h0, 8'h00); drain();
        cfg_long_reset = 1'b0; cfg_shifted = 1'b0;
        cur_tag = "R8"; cfg_zero_gap = 1'b1;
        issue(1, 20'h54321, 8'h00); drain();
        cfg_zero_gap = 1'b0;
        cur_tag = "R10";
        issue(0, 20'h00FFF, 8'h5A);
        cfg_shifted = 1'b1; cfg_mask_sel = 2'd1; cfg_zero_gap = 1'b1;
        repeat (3) @(negedge clk);
        issue(3, 20'h0, 8'h00);       // ignored: busy
        issue(7, 20'h0, 8'h00);       // ignored: busy and reserved
        drain();
        issue(7, 20'h11111, 8'h77); drain(); // reserved op while idle
        cfg_shifted = 1'b0; cfg_mask_sel = 2'd0; cfg_zero_gap = 1'b0;
        cur_tag = "R9"; // back-to-back: second request right after done
        issue(4, 20'h0, 8'h00);
        while (expq.size() != 0) @(negedge clk);
        issue(6, 20'h0, 8'h00); drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule